// File: doc/BRIEF.md
# Half-Bridge Dead-Band Generator

This block turns one raw PWM drive signal into a pair of complementary gate signals, one for the upper switch of a half-bridge and one for the lower switch. When the PWM input is high the upper side is asked to conduct; when it is low the lower side is. The upper gate follows the PWM level and the lower gate follows its complement.

A power switch takes longer to stop conducting than to start. The block therefore postpones every switch-on by a programmable number of delay units, which gives the opposite switch time to stop conducting first. Switch-off is never postponed. A delay unit is marked by a one-clock `unit_tick` strobe, nominally once every four clocks. The delay count is 7 bits wide. Each gate has its own polarity setting, so active-low gate drivers can be used. All delay logic works on the logical "on" state, before polarity is applied.

Top module: `hbdb_top`

## Requirements
- R1: While `rst_n` is low, both sides are logically off, so each gate sits at its inactive level: 0 when its invert input is 0, and 1 when its invert input is 1.
- R2: The two sides are never logically on in the same cycle.
- R3: When a side's request drops (PWM low for the upper side, PWM high for the lower side), that side is off from the next clock edge. No delay unit is waited for.
- R4: With a nonzero count D, a side that is requested while off turns on at the clock edge that samples the D-th `unit_tick` after the edge that first saw the request. A tick sampled on that first edge does not count.
- R5: With a count of 0, a requested side turns on at the clock edge right after the request appears, so the gates are plainly complementary.
- R6: If the request drops before the delay runs out, the pending switch-on is cancelled. The next request starts a full new delay.
- R7: The count is captured on the edge where a delay starts. Changing `dead_cnt` while that delay runs does not change its length.
- R8: A gate equals the logical on state XOR its invert input, so invert = 1 drives the gate low while the side is on.
- R9: The full range up to 127 units works. The side turns on after exactly 127 ticks.
- R10: Only clocks with `unit_tick` high move a running delay forward. With no ticks, a pending side stays off for as long as it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_tick | input | 1 | One-clock strobe marking one delay unit |
| pwm_in | input | 1 | Raw PWM level: 1 requests upper, 0 requests lower |
| dead_cnt | input | 7 | Switch-on delay in delay units |
| upper_inv | input | 1 | 1 = upper gate is active low |
| lower_inv | input | 1 | 1 = lower gate is active low |
| gate_upper | output | 1 | Upper switch gate |
| gate_lower | output | 1 | Lower switch gate |

## Verification
The hardest cases to reach from the ports are a delay that is interrupted by a PWM edge, and a count that changes partway through a delay. Both need the input change to land between two particular ticks. The stimulus sets the tick phase from the bench and holds the PWM level for a chosen number of clocks that ends before the delay runs out. It also rewrites `dead_cnt` a few clocks after a switch-on request. A per-cycle scoreboard then compares both gates against the expected on states every cycle, and it covers a stretch with ticks suppressed and a run at the largest count.

// File: rtl/hbdb_pkg.sv
package hbdb_pkg;

  typedef enum logic [1:0] {
    SIDE_OFF  = 2'd0,
    SIDE_WAIT = 2'd1,
    SIDE_ON   = 2'd2
  } side_state_t;

  localparam int SIDE_UPPER = 0;
  localparam int SIDE_LOWER = 1;
  localparam int NUM_SIDES  = 2;

  // Remaining units after one more tick has been seen.
  function automatic logic [15:0] count_step(input logic [15:0] cur);
    return (cur == 16'd0) ? 16'd0 : cur - 16'd1;
  endfunction

  // True when the tick now being seen is the last one of the delay.
  function automatic logic count_last(input logic [15:0] cur);
    return cur == 16'd1;
  endfunction

  // Physical gate level from the logical on state and the invert setting.
  function automatic logic drive_level(input logic on, input logic inv);
    return on ^ inv;
  endfunction

endpackage

// File: rtl/hbdb_req_split.sv
module hbdb_req_split
  import hbdb_pkg::*;
(
  input  logic                 pwm_i,
  output logic [NUM_SIDES-1:0] req_o
);
  always_comb begin
    req_o             = '0;
    req_o[SIDE_UPPER] = pwm_i;
    req_o[SIDE_LOWER] = ~pwm_i;
  end
endmodule

// File: rtl/hbdb_edge_delay.sv
module hbdb_edge_delay
  import hbdb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             act_o
);
  localparam int PAD_W = 16 - CNT_W;

  side_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named events, visible to the assertions below.
  logic start_ev, zero_start, expire_ev, cancel_ev;
  logic [15:0] cnt_wide, cnt_next_wide;

  assign cnt_wide      = {{PAD_W{1'b0}}, cnt_q};
  assign cnt_next_wide = count_step(cnt_wide);
  assign start_ev      = (state_q == SIDE_OFF) && req_i;
  assign zero_start    = start_ev && (dly_i == '0);
  assign expire_ev     = (state_q == SIDE_WAIT) && req_i && tick_i && count_last(cnt_wide);
  assign cancel_ev     = (state_q == SIDE_WAIT) && !req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SIDE_OFF: begin
        if (zero_start) begin
          state_d = SIDE_ON;
        end else if (start_ev) begin
          state_d = SIDE_WAIT;
          cnt_d   = dly_i;
        end
      end
      SIDE_WAIT: begin
        if (cancel_ev) begin
          state_d = SIDE_OFF;
        end else if (expire_ev) begin
          state_d = SIDE_ON;
        end else if (tick_i) begin
          cnt_d = cnt_next_wide[CNT_W-1:0];
        end
      end
      SIDE_ON: begin
        if (!req_i) state_d = SIDE_OFF;
      end
      default: state_d = SIDE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SIDE_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign act_o = (state_q == SIDE_ON);

  assert_off_prompt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !act_o);

  assert_wait_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SIDE_WAIT && !tick_i) |=> !act_o);

  assert_zero_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> act_o);

  assert_cnt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SIDE_WAIT && !tick_i && req_i) |=> $stable(cnt_q));

  assert_cancel_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_ev |=> (state_q == SIDE_OFF));

endmodule

// File: rtl/hbdb_out_drive.sv
module hbdb_out_drive
  import hbdb_pkg::*;
(
  input  logic act_i,
  input  logic inv_i,
  output logic gate_o
);
  assign gate_o = drive_level(act_i, inv_i);
endmodule

// File: rtl/hbdb_top.sv
module hbdb_top
  import hbdb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_tick,
  input  logic             pwm_in,
  input  logic [CNT_W-1:0] dead_cnt,
  input  logic             upper_inv,
  input  logic             lower_inv,
  output logic             gate_upper,
  output logic             gate_lower
);
  logic [NUM_SIDES-1:0] req;
  logic [NUM_SIDES-1:0] act;
  logic [NUM_SIDES-1:0] inv;
  logic [NUM_SIDES-1:0] gate;

  assign inv[SIDE_UPPER] = upper_inv;
  assign inv[SIDE_LOWER] = lower_inv;

  hbdb_req_split u_split (
    .pwm_i (pwm_in),
    .req_o (req)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hbdb_edge_delay #(.CNT_W(CNT_W)) u_dly (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (unit_tick),
      .req_i  (req[s]),
      .dly_i  (dead_cnt),
      .act_o  (act[s])
    );
    hbdb_out_drive u_drv (
      .act_i  (act[s]),
      .inv_i  (inv[s]),
      .gate_o (gate[s])
    );
  end

  assign gate_upper = gate[SIDE_UPPER];
  assign gate_lower = gate[SIDE_LOWER];

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= 1);

  always_comb begin
    if (!rst_n) assert_reset_off_R1: assert (act == '0);
  end

endmodule

// File: tb/hbdb_top_tb.sv
module hbdb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       unit_tick = 1'b0;
  logic       pwm_in = 1'b0;
  logic [6:0] dead_cnt = 7'd0;
  logic       upper_inv = 1'b0;
  logic       lower_inv = 1'b0;
  logic       gate_upper, gate_lower;
  logic       tick_en = 1'b1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  string cur_tag = "R1";

  typedef struct { bit up; bit lo; } exp_t;
  exp_t exp_q[$];

  hbdb_top u_dut (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .pwm_in(pwm_in),
    .dead_cnt(dead_cnt), .upper_inv(upper_inv), .lower_inv(lower_inv),
    .gate_upper(gate_upper), .gate_lower(gate_lower)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick source: one strobe every four clocks, driven at the falling edge.
  int tick_phase = 0;
  always @(negedge clk) begin
    tick_phase = (tick_phase + 1) % 4;
    unit_tick  = tick_en && (tick_phase == 0);
  end

  // Expected on states: a side counts ticks seen since its request began
  // and turns on once the captured target is reached.
  bit m_on[2], m_wait[2];
  int m_seen[2], m_goal[2];
  always @(posedge clk) begin
    exp_t e;
    for (int s = 0; s < 2; s++) begin
      bit rq;
      rq = (s == 0) ? pwm_in : !pwm_in;
      if (!rst_n || !rq) begin
        m_on[s] = 0; m_wait[s] = 0;
      end else if (!m_on[s] && !m_wait[s]) begin
        if (dead_cnt == 0) m_on[s] = 1;
        else begin m_wait[s] = 1; m_seen[s] = 0; m_goal[s] = dead_cnt; end
      end else if (m_wait[s] && unit_tick) begin
        m_seen[s]++;
        if (m_seen[s] >= m_goal[s]) begin m_on[s] = 1; m_wait[s] = 0; end
      end
    end
    e.up = m_on[0]; e.lo = m_on[1];
    exp_q.push_back(e);
  end

  // Monitor: compares after the falling edge, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      bit xu, xl;
      e  = exp_q.pop_front();
      xu = e.up ^ upper_inv;
      xl = e.lo ^ lower_inv;
      checks++;
      if (gate_upper !== xu) begin
        fails++;
        $display("FAIL %s upper gate actual=%b expected=%b t=%0t", cur_tag, gate_upper, xu, $time);
      end
      checks++;
      if (gate_lower !== xl) begin
        fails++;
        $display("FAIL %s lower gate actual=%b expected=%b t=%0t", cur_tag, gate_lower, xl, $time);
      end
      checks++;
      if ((gate_upper ^ upper_inv) && (gate_lower ^ lower_inv)) begin
        fails++;
        $display("FAIL R2 overlap actual=both_on expected=at_most_one t=%0t", $time);
      end
    end
  end

  task automatic hold(input bit lvl, input int n);
    pwm_in = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R1: reset state at both polarity settings
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    upper_inv = 1; lower_inv = 1;
    repeat (3) @(negedge clk);
    upper_inv = 0; lower_inv = 0;
    @(negedge clk);
    rst_n = 1;
    hold(0, 8);

    // R4: count of 3, turn-on waits three ticks; R3: switch-off at once
    cur_tag = "R4"; dead_cnt = 7'd3;
    hold(1, 30); cur_tag = "R3"; hold(0, 30);
    hold(1, 25); hold(0, 25);

    // R5: zero count, plain complementary drive
    cur_tag = "R5"; dead_cnt = 7'd0;
    for (int i = 0; i < 6; i++) begin hold(1, 3 + i); hold(0, 2 + i); end

    // R6: request withdrawn mid-delay, then a fresh full delay
    cur_tag = "R6"; dead_cnt = 7'd5;
    hold(0, 30); hold(1, 9); hold(0, 3); hold(1, 40); hold(0, 11); hold(1, 2); hold(0, 40);

    // R7: count rewritten while a delay runs
    cur_tag = "R7"; dead_cnt = 7'd6;
    pwm_in = 1; repeat (5) @(negedge clk);
    dead_cnt = 7'd1; repeat (35) @(negedge clk);
    dead_cnt = 7'd6; pwm_in = 0; repeat (5) @(negedge clk);
    dead_cnt = 7'd1; repeat (35) @(negedge clk);

    // R10: ticks suppressed, pending side stays off
    cur_tag = "R10"; dead_cnt = 7'd2; tick_en = 0;
    hold(1, 40); tick_en = 1; hold(1, 20); hold(0, 20);

    // R8: active-low gates
    cur_tag = "R8"; upper_inv = 1; lower_inv = 1;
    for (int i = 0; i < 3; i++) begin hold(1, 20); hold(0, 20); end
    upper_inv = 0;
    hold(1, 20); hold(0, 20);
    lower_inv = 0;

    // R9: largest count
    cur_tag = "R9"; dead_cnt = 7'd127;
    hold(1, 530); hold(0, 530);

    cur_tag = "R2"; dead_cnt = 7'd1;
    for (int i = 0; i < 10; i++) begin hold(1, 1 + i); hold(0, 7 - (i % 5)); end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule